// File: doc/BRIEF.md
# Command-Driven Random Generator Core

This block is the register-visible front end of a true random number source. Software drives it through a small command field: a seed command collects a fixed number of words from an external entropy stream into an internal pool, and a generate command produces either a 128-bit or a 256-bit result. The result appears in eight readable 32-bit words. Busy flags in a status word show whether the core is seeding or generating. A write-one-to-clear interrupt status register records two events: seeding finished and result ready. An interrupt line combines these bits with per-event enables and a global enable.

The core counts how much output it has produced, in 16-byte units. When the count reaches a programmable threshold, it reseeds itself right after the generation that reached it. A generate command issued before any seeding runs a seed pass first. The conditioning stage is a plain xorshift mixer that is keyed by the pool. A read-only identification word allows software to recognise the block.

Top module: `rng_cmd_core`

## Requirements
- R1: After reset, these registers all read zero: status (0x04), mode (0x08), interrupt enable (0x10), interrupt status (0x14), result word 0x20 and threshold (0x60). The interrupt output is low.
- R2: Address 0xF0 always reads 0x0000_46BC, and writes to it have no effect.
- R3: Writing 2 to bits [1:0] of 0x00 while idle starts a seed pass. Status bit 31 is high and ent_ready is high until SEED_WORDS (4) words have been accepted, each word taken on a cycle with ent_valid high. After the last word, status bit 9 (seeded) is set, interrupt status bit 1 is set and the core returns to idle. The seeded bit never clears.
- R4: Writing 1 to bits [1:0] of 0x00 while unseeded first runs a seed pass with status bit 31 high and bit 30 low. Generation starts on the edge that accepts the last seed word.
- R5: With mode bit 3 set to 1, a generation keeps status bit 30 high for exactly 1024 cycles, counted from the edge that starts it. On the next state the bit is low and interrupt status bit 0 is set. The 256-bit result is held in words 0x20 to 0x3C.
- R6: With mode bit 3 set to 0, a generation lasts 512 cycles. Words 0x30 to 0x3C then read zero.
- R7: Two successive generations leave different result words.
- R8: A command written while status bit 30 or 31 is high is ignored. Command codes 0 and 3 have no effect.
- R9: Writing 1 to a bit of 0x14 clears that bit, and writing 0 leaves it unchanged.
- R10: The interrupt output equals enable bit 31 AND ((enable bit 0 AND status bit 0) OR (enable bit 1 AND status bit 1)). The enable register reads back bits 31, 1 and 0.
- R11: Each generation adds 1 (128-bit) or 2 (256-bit) to an output count. When a generation brings the count to the threshold at 0x60 or above, the core clears the count and enters a seed pass on the same edge that sets interrupt status bit 0. A threshold of 0 disables this. A seed command also clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ent_valid | input | 1 | Entropy word present |
| ent_data | input | 32 | Entropy word |
| ent_ready | output | 1 | Core is collecting seed words |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software lowers the threshold only when the running count is already below the new value. The bench therefore writes a new threshold only right after a seed pass, when the count has just been cleared. They also assume that the entropy source presents a word only when ent_ready is high. The bench raises ent_valid only during a seed pass that it has already seen in the status word. Register writes are issued one per cycle with stable address and data, so no write and no seed word straddles a clock edge.

// File: rtl/rng_pkg.sv
`timescale 1ns/1ps
package rng_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SEED, ST_GEN} rng_state_e;

    localparam logic [7:0] A_CMD  = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_MODE = 8'h08;
    localparam logic [7:0] A_IE   = 8'h10;
    localparam logic [7:0] A_ISR  = 8'h14;
    localparam logic [7:0] A_THR  = 8'h60;
    localparam logic [7:0] A_VER  = 8'hF0;
    localparam logic [2:0] A_RES_HI = 3'b001;

    localparam logic [1:0] CMD_GEN  = 2'd1;
    localparam logic [1:0] CMD_SEED = 2'd2;
endpackage

// File: rtl/rng_seed_pool.sv
`timescale 1ns/1ps
module rng_seed_pool #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         absorb,
    input  logic [W-1:0] din,
    output logic [W-1:0] pool_o
);
    logic [W-1:0] pool_d, pool_q;

    always_comb begin
        pool_d = pool_q;
        if (absorb) pool_d = {pool_q[W-8:0], pool_q[W-1:W-7]} ^ din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pool_q <= '0;
        else        pool_q <= pool_d;
    end

    assign pool_o = pool_q;
endmodule

// File: rtl/rng_result_bank.sv
`timescale 1ns/1ps
module rng_result_bank #(
    parameter int W  = 32,
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                step,
    input  logic                cap_en,
    input  logic [IW-1:0]       cap_idx,
    input  logic [W-1:0]        seed_i,
    output logic [N-1:0][W-1:0] words_o
);
    logic [W-1:0]        mix_d, mix_q;
    logic [N-1:0][W-1:0] words_d, words_q;

    function automatic logic [W-1:0] xs(input logic [W-1:0] v);
        logic [W-1:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    always_comb begin
        mix_d   = mix_q;
        words_d = words_q;
        if (start) begin
            mix_d   = (mix_q ^ seed_i) | W'(1);
            words_d = '0;
        end else if (step) begin
            mix_d = xs(mix_q);
            if (cap_en) words_d[cap_idx] = mix_q ^ seed_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mix_q   <= W'(32'h2545_F491);
            words_q <= '0;
        end else begin
            mix_q   <= mix_d;
            words_q <= words_d;
        end
    end

    assign words_o = words_q;

    assert_mix_alive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> (mix_q != '0));
endmodule

// File: rtl/rng_reseed_tracker.sv
`timescale 1ns/1ps
module rng_reseed_tracker #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          credit,
    input  logic [1:0]    units,
    input  logic [CW-1:0] thresh,
    output logic          due_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + {{(CW-1){1'b0}}, units};
        due_o = (thresh != '0) && (sum >= {1'b0, thresh});
        cnt_d = cnt_q;
        if (clear)       cnt_d = '0;
        else if (credit) cnt_d = due_o ? '0 : sum[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_count_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !credit) |=> $stable(cnt_q));
    assert_count_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh != '0 && $stable(thresh)) |-> (cnt_q < thresh));
endmodule

// File: rtl/rng_cmd_core.sv
`timescale 1ns/1ps
module rng_cmd_core
    import rng_pkg::*;
#(
    parameter int          GEN_CYCLES = 1024,
    parameter int          SEED_WORDS = 4,
    parameter int          CNT_W      = 16,
    parameter logic [31:0] VERSION    = 32'h0000_46BC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ent_valid,
    input  logic [31:0] ent_data,
    output logic        ent_ready,
    output logic        irq
);
    localparam int RES_WORDS = 8;
    localparam int IDX_W     = $clog2(RES_WORDS);
    localparam int GCNT_W    = $clog2(GEN_CYCLES);
    localparam int STEP_W    = $clog2(GEN_CYCLES / RES_WORDS);
    localparam int SCNT_W    = $clog2(SEED_WORDS + 1);
    localparam logic [GCNT_W-1:0] LAST_WIDE   = GCNT_W'(GEN_CYCLES - 1);
    localparam logic [GCNT_W-1:0] LAST_NARROW = GCNT_W'(GEN_CYCLES / 2 - 1);
    localparam logic [SCNT_W-1:0] SEED_LAST   = SCNT_W'(SEED_WORDS - 1);

    typedef struct packed {
        rng_state_e          st;
        logic                pend_gen;
        logic                wide;
        logic                seeded;
        logic                mode;
        logic [2:0]          ie;
        logic [1:0]          isr;
        logic [SCNT_W-1:0]   scnt;
        logic [GCNT_W-1:0]   gcnt;
        logic [CNT_W-1:0]    thr;
    } regs_t;

    regs_t r_d, r_q;
    logic gen_start, gen_done, seed_done, ctr_clear, due, seed_fire;
    logic cap_en, wr_cmd, wdata_unused;
    logic [31:0] pool;
    logic [RES_WORDS-1:0][31:0] words;

    assign wdata_unused = ^bus_wdata;
    assign wr_cmd    = bus_we && (bus_addr == A_CMD);
    assign ent_ready = (r_q.st == ST_SEED);
    assign seed_fire = ent_ready && ent_valid;
    assign cap_en    = (r_q.st == ST_GEN) && (r_q.gcnt[STEP_W-1:0] == {STEP_W{1'b1}});

    always_comb begin
        r_d       = r_q;
        gen_start = 1'b0;
        gen_done  = 1'b0;
        seed_done = 1'b0;
        ctr_clear = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (wr_cmd && bus_wdata[1:0] == CMD_SEED) begin
                    r_d.st = ST_SEED; r_d.pend_gen = 1'b0; r_d.scnt = '0; ctr_clear = 1'b1;
                end else if (wr_cmd && bus_wdata[1:0] == CMD_GEN) begin
                    if (r_q.seeded) begin
                        r_d.st = ST_GEN; r_d.gcnt = '0; r_d.wide = r_q.mode; gen_start = 1'b1;
                    end else begin
                        r_d.st = ST_SEED; r_d.pend_gen = 1'b1; r_d.scnt = '0; ctr_clear = 1'b1;
                    end
                end
            end
            ST_SEED: begin
                if (ent_valid) begin
                    r_d.scnt = r_q.scnt + 1'b1;
                    if (r_q.scnt == SEED_LAST) begin
                        r_d.seeded   = 1'b1;
                        seed_done    = 1'b1;
                        r_d.pend_gen = 1'b0;
                        if (r_q.pend_gen) begin
                            r_d.st = ST_GEN; r_d.gcnt = '0; r_d.wide = r_q.mode; gen_start = 1'b1;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
            end
            ST_GEN: begin
                r_d.gcnt = r_q.gcnt + 1'b1;
                if (r_q.gcnt == (r_q.wide ? LAST_WIDE : LAST_NARROW)) begin
                    gen_done = 1'b1;
                    if (due) begin
                        r_d.st = ST_SEED; r_d.scnt = '0; r_d.pend_gen = 1'b0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (bus_we && bus_addr == A_MODE) r_d.mode = bus_wdata[3];
        if (bus_we && bus_addr == A_IE)   r_d.ie   = {bus_wdata[31], bus_wdata[1:0]};
        if (bus_we && bus_addr == A_THR)  r_d.thr  = bus_wdata[CNT_W-1:0];
        if (bus_we && bus_addr == A_ISR)  r_d.isr  = r_q.isr & ~bus_wdata[1:0];
        if (gen_done)  r_d.isr[0] = 1'b1;
        if (seed_done) r_d.isr[1] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    rng_seed_pool #(.W(32)) u_pool (
        .clk(clk), .rst_n(rst_n), .absorb(seed_fire), .din(ent_data), .pool_o(pool)
    );

    rng_result_bank #(.W(32), .N(RES_WORDS), .IW(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .start(gen_start), .step(r_q.st == ST_GEN),
        .cap_en(cap_en), .cap_idx(r_q.gcnt[GCNT_W-1:STEP_W]), .seed_i(pool), .words_o(words)
    );

    rng_reseed_tracker #(.CW(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .credit(gen_done),
        .units(r_q.wide ? 2'd2 : 2'd1), .thresh(r_q.thr), .due_o(due)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[7:5] == A_RES_HI && bus_addr[1:0] == 2'b00) begin
            bus_rdata = words[bus_addr[4:2]];
        end else begin
            case (bus_addr)
                A_STAT: bus_rdata = {r_q.st == ST_SEED, r_q.st == ST_GEN, 20'b0, r_q.seeded, 9'b0};
                A_MODE: bus_rdata = {28'b0, r_q.mode, 3'b0};
                A_IE:   bus_rdata = {r_q.ie[2], 29'b0, r_q.ie[1:0]};
                A_ISR:  bus_rdata = {30'b0, r_q.isr};
                A_THR:  bus_rdata = {{(32-CNT_W){1'b0}}, r_q.thr};
                A_VER:  bus_rdata = VERSION;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = r_q.ie[2] & ((r_q.ie[0] & r_q.isr[0]) | (r_q.ie[1] & r_q.isr[1]));

    assert_ready_from_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.isr[0]) |-> $past(r_q.st == ST_GEN));
    assert_seeded_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.seeded |=> r_q.seeded);
    assert_gen_seeded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_GEN) |-> r_q.seeded);
    assert_seed_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEED && !ent_valid) |=> (r_q.st == ST_SEED));
    assert_irq_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> r_q.ie[2]);
endmodule

// File: tb/sim_rng_cmd_core.sv
`timescale 1ns/1ps
module sim_rng_cmd_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ent_valid = 1'b0;
    logic [31:0] ent_data = '0;
    logic        ent_ready;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] prev [8];

    always #2 clk = ~clk;

    rng_cmd_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ent_valid(ent_valid),
        .ent_data(ent_data), .ent_ready(ent_ready), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.1;
        d = bus_rdata;
    endtask

    task automatic feed(int n, int salt);
        for (int i = 0; i < n; i++) begin
            ent_valid = 1'b1;
            ent_data  = 32'h9E37_79B9 * (i + 1) + salt;
            @(posedge clk); #1;
        end
        ent_valid = 1'b0;
    endtask

    // Wait out a generation that started on the previous edge; check busy then done.
    task automatic wait_gen(int total, string req);
        logic [31:0] s, q;
        repeat (total - 1) @(posedge clk);
        #1;
        rd(8'h04, s); rd(8'h14, q);
        check({req, " busy on last cycle"}, {s[30], q[0]}, 32'h2);
        @(posedge clk); #1;
        rd(8'h04, s); rd(8'h14, q);
        check({req, " done"}, {s[30], q[0]}, 32'h1);
    endtask

    task automatic gen(logic wide, string req);
        wr(8'h14, 32'h3);
        wr(8'h00, 32'h1);
        wait_gen(wide ? 1024 : 512, req);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(8'h04, d); check("R1 status", d, 0);
        rd(8'h08, d); check("R1 mode", d, 0);
        rd(8'h10, d); check("R1 ie", d, 0);
        rd(8'h14, d); check("R1 isr", d, 0);
        rd(8'h20, d); check("R1 word0", d, 0);
        rd(8'h60, d); check("R1 thr", d, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_version;
        logic [31:0] d;
        rd(8'hF0, d); check("R2 version", d, 32'h46BC);
        wr(8'hF0, 32'hFFFF_FFFF);
        rd(8'hF0, d); check("R2 version after write", d, 32'h46BC);
    endtask

    task automatic t_unseeded_gen;
        logic [31:0] s;
        wr(8'h08, 32'h8);
        wr(8'h00, 32'h1);
        rd(8'h04, s);
        check("R4 seeding before generate", {s[31], s[30], s[9], ent_ready}, 32'b1001);
        feed(3, 5);
        rd(8'h04, s); check("R3 still collecting", {s[31], s[9]}, 32'b10);
        feed(1, 9);
        rd(8'h04, s); check("R4 generation follows seed", {s[31], s[30], s[9]}, 32'b011);
        wait_gen(1024, "R5 256-bit after seed");
        rd(8'h14, s); check("R3 seed-done bit", s[1], 1);
        for (int i = 0; i < 8; i++) rd(8'h20 + 8'(4 * i), prev[i]);
    endtask

    task automatic t_gen256;
        logic [31:0] w;
        int same;
        gen(1'b1, "R5 256-bit");
        same = 0;
        for (int i = 0; i < 8; i++) begin
            rd(8'h20 + 8'(4 * i), w);
            if (w == prev[i]) same++;
            prev[i] = w;
        end
        check("R7 words changed", same, 0);
    endtask

    task automatic t_gen128;
        logic [31:0] w;
        wr(8'h08, 32'h0);
        gen(1'b0, "R6 128-bit");
        for (int i = 4; i < 8; i++) begin
            rd(8'h20 + 8'(4 * i), w);
            check("R6 upper word zero", w, 0);
        end
    endtask

    task automatic t_busy_ignore;
        logic [31:0] s;
        wr(8'h08, 32'h8);
        wr(8'h14, 32'h3);
        wr(8'h00, 32'h1);
        wr(8'h00, 32'h2);
        wr(8'h00, 32'h1);
        repeat (1021) @(posedge clk);
        #1;
        rd(8'h04, s); check("R8 still generating", s[30], 1);
        @(posedge clk); #1;
        rd(8'h04, s);
        check("R8 R11 idle after busy writes, no reseed at thr 0", {s[31], s[30], ent_ready}, 0);
        wr(8'h00, 32'h3);
        rd(8'h04, s); check("R8 code 3 no effect", {s[31], s[30]}, 0);
        wr(8'h00, 32'h0);
        rd(8'h04, s); check("R8 code 0 no effect", {s[31], s[30]}, 0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(8'h10, 32'h0000_0001); check("R10 no global enable", irq, 0);
        wr(8'h10, 32'h8000_0002); check("R10 seed-done not pending", irq, 0);
        wr(8'h10, 32'h8000_0001); check("R10 ready enabled", irq, 1);
        rd(8'h10, d); check("R10 ie readback", d, 32'h8000_0001);
        wr(8'h14, 32'h2);
        rd(8'h14, d); check("R9 W1C on clear bit no effect", d, 1);
        wr(8'h14, 32'h0);
        rd(8'h14, d); check("R9 writing zero keeps bit", d, 1);
        wr(8'h14, 32'h1);
        rd(8'h14, d); check("R9 W1C clears", d, 0);
        check("R10 irq drops", irq, 0);
    endtask

    task automatic t_seed_cmd;
        logic [31:0] s;
        wr(8'h10, 32'h8000_0002);
        wr(8'h00, 32'h2);
        rd(8'h04, s); check("R3 seed cmd reseeding", {s[31], s[30], ent_ready}, 32'b101);
        feed(3, 77);
        check("R3 no irq mid seed", irq, 0);
        feed(1, 78);
        rd(8'h04, s); check("R3 seed cmd done", {s[31], s[9]}, 32'b01);
        rd(8'h14, s); check("R3 seed-done status", s, 2);
        check("R10 seed-done irq", irq, 1);
        wr(8'h14, 32'h3);
        wr(8'h10, 32'h0);
    endtask

    task automatic t_auto_reseed;
        logic [31:0] s;
        wr(8'h60, 32'd2);
        wr(8'h08, 32'h8);
        gen(1'b1, "R11 256-bit reaching threshold");
        rd(8'h04, s); check("R11 auto reseed after 2 units", {s[31], s[30], ent_ready}, 32'b101);
        feed(4, 300);
        rd(8'h04, s); check("R11 reseed completes", {s[31], s[9]}, 32'b01);
        wr(8'h60, 32'd3);
        wr(8'h08, 32'h0);
        gen(1'b0, "R11 128 first");
        rd(8'h04, s); check("R11 count 1 below 3", s[31], 0);
        gen(1'b0, "R11 128 second");
        rd(8'h04, s); check("R11 count 2 below 3", s[31], 0);
        gen(1'b0, "R11 128 third");
        rd(8'h04, s); check("R11 count 3 reseeds", s[31], 1);
        feed(4, 400);
        rd(8'h04, s); check("R11 back to idle", {s[31], s[30]}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_version();
        t_unseeded_gen();
        t_gen256();
        t_gen128();
        t_busy_ignore();
        t_irq();
        t_seed_cmd();
        t_auto_reseed();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule